// File: doc/BRIEF.md
# Sequencer Interrupt Status and Clear Unit

This unit collects completion events from four sample sequencers and turns them into per-source level interrupts. Each source keeps a pending flag, which is set by a one-cycle event pulse and held until software acknowledges it. Each source also has an enable bit. A source raises its interrupt line while its pending flag and its enable bit are both 1.

Software reaches three registers over a simple synchronous bus:
- a read-only view of the pending flags,
- a read/write enable register,
- a masked status register.

Reading the masked status register returns pending AND enable. Writing a 1 to a bit of that register clears the matching pending flag, even when that source is disabled. This lets a design that polls the raw flags acknowledge events through the same register it would use with interrupts.

Top module: `seq_irq_unit`

## Requirements
- R1: After reset the pending flags, the enable bits and the read data are all zero, and every interrupt output is low.
- R2: A 1 on `evt_pulse[n]` sets pending flag n at the next rising clock edge. The flag stays 1 until it is cleared.
- R3: A read at offset 0x00C returns in bit n the AND of pending flag n and enable bit n, for n = 0..3.
- R4: `irq_out[n]` is high exactly while pending flag n and enable bit n are both 1.
- R5: Writing offset 0x00C clears pending flag n where data bit n is 1. Flags whose data bit is 0 keep their value.
- R6: The clear of R5 works even when enable bit n is 0, that is, while status bit n reads 0.
- R7: When an event pulse and a clear for the same bit fall in the same cycle, the flag ends up set.
- R8: Offset 0x008 holds the enable bits in data bits 3:0. A write stores them and a read returns them. Bits 31:4 read as 0.
- R9: Offset 0x004 returns the pending flags in bits 3:0. Writes to it are ignored.
- R10: Read data is registered. It appears one cycle after the read strobe and holds until the next read. A read of any address other than 0x004, 0x008 or 0x00C returns 0.
- R11: Bits 31:4 of the status register read as 0. Writing them changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| bus_addr | input | 12 | Byte address of the register access |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| evt_pulse | input | 4 | Sequencer event pulses, one per source |
| irq_out | output | 4 | Level interrupt, one per source |

## Verification
The bench builds the unit with its default parameters: four sources, a 12-bit address and a 32-bit data word. With these values every source bit and every reserved status bit can be reached directly from bus writes.

Directed scenarios cover the harder cases:
- clearing a source whose enable bit is off,
- an event and a clear for the same bit landing in the same cycle,
- writes to the read-only pending view,
- reads of unmapped addresses.

Each scenario checks both the read data and the interrupt lines.

// File: rtl/sqirq_pkg.sv
// Shared types for the sequencer interrupt unit.
// Assumes nothing beyond being compiled before the modules that import it.
package sqirq_pkg;
    typedef enum logic [1:0] {
        SEL_NONE = 2'd0,
        SEL_RAW  = 2'd1,
        SEL_MASK = 2'd2,
        SEL_STAT = 2'd3
    } reg_sel_e;
endpackage

// File: rtl/sqirq_decode.sv
// Address decoder: picks the register addressed by a bus cycle and
// derives the write strobes. Assumes full word-address compares.
module sqirq_decode
    import sqirq_pkg::*;
#(
    parameter int ADDR_W   = 12,
    parameter int RAW_OFS  = 'h004,
    parameter int MASK_OFS = 'h008,
    parameter int STAT_OFS = 'h00C
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr,
    output reg_sel_e          sel,
    output logic              wr_mask,
    output logic              wr_clr
);
    localparam logic [ADDR_W-1:0] A_RAW  = ADDR_W'(RAW_OFS);
    localparam logic [ADDR_W-1:0] A_MASK = ADDR_W'(MASK_OFS);
    localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(STAT_OFS);

    // Map the address onto a register select.
    always_comb begin
        if (addr == A_RAW)       sel = SEL_RAW;
        else if (addr == A_MASK) sel = SEL_MASK;
        else if (addr == A_STAT) sel = SEL_STAT;
        else                     sel = SEL_NONE;
    end

    // Derive write strobes. The raw view has no write strobe.
    always_comb begin
        wr_mask = wr && (sel == SEL_MASK);
        wr_clr  = wr && (sel == SEL_STAT);
    end
endmodule

// File: rtl/sqirq_flag.sv
// One source slice: a pending flag with set priority, and an enable bit.
// Assumes evt is a synchronous pulse in the clk domain.
module sqirq_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic evt,
    input  logic clr,
    input  logic mask_we,
    input  logic mask_d,
    output logic raw_q,
    output logic mask_q
);
    // Pending flag: an event wins over a clear in the same cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)   raw_q <= 1'b0;
        else if (evt) raw_q <= 1'b1;
        else if (clr) raw_q <= 1'b0;
    end

    // Enable bit: loaded by a write to the enable register.
    always_ff @(posedge clk) begin
        if (!rst_n)       mask_q <= 1'b0;
        else if (mask_we) mask_q <= mask_d;
    end
endmodule

// File: rtl/sqirq_readback.sv
// Registered read multiplexer. Zero-extends the per-source vectors to the
// bus width. Holds the last value between reads. Assumes DATA_W >= NSRC.
module sqirq_readback
    import sqirq_pkg::*;
#(
    parameter int NSRC   = 4,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd,
    input  reg_sel_e          sel,
    input  logic [NSRC-1:0]   raw,
    input  logic [NSRC-1:0]   mask,
    output logic [DATA_W-1:0] rdata
);
    logic [DATA_W-1:0] word;

    // Build the word for the selected register. Unmapped addresses give 0.
    always_comb begin
        word = '0;
        case (sel)
            SEL_RAW:  word[NSRC-1:0] = raw;
            SEL_MASK: word[NSRC-1:0] = mask;
            SEL_STAT: word[NSRC-1:0] = raw & mask;
            default:  word = '0;
        endcase
    end

    // Capture the word on a read strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)  rdata <= '0;
        else if (rd) rdata <= word;
    end
endmodule

// File: rtl/seq_irq_unit.sv
// Top of the sequencer interrupt unit. Holds one flag slice per source,
// decodes bus accesses, clears flags by write-one-to-clear, and drives
// level interrupts. Assumes one synchronous bus and clock domain.
module seq_irq_unit
    import sqirq_pkg::*;
#(
    parameter int NSRC     = 4,
    parameter int ADDR_W   = 12,
    parameter int DATA_W   = 32,
    parameter int RAW_OFS  = 'h004,
    parameter int MASK_OFS = 'h008,
    parameter int STAT_OFS = 'h00C
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [NSRC-1:0]   evt_pulse,
    output logic [NSRC-1:0]   irq_out
);
    reg_sel_e        sel;
    logic            wr_mask;
    logic            wr_clr;
    logic [NSRC-1:0] raw_q;
    logic [NSRC-1:0] mask_q;

    sqirq_decode #(
        .ADDR_W  (ADDR_W),
        .RAW_OFS (RAW_OFS),
        .MASK_OFS(MASK_OFS),
        .STAT_OFS(STAT_OFS)
    ) u_dec (
        .addr   (bus_addr),
        .wr     (bus_wr),
        .sel    (sel),
        .wr_mask(wr_mask),
        .wr_clr (wr_clr)
    );

    for (genvar i = 0; i < NSRC; i++) begin : g_src
        sqirq_flag u_flag (
            .clk    (clk),
            .rst_n  (rst_n),
            .evt    (evt_pulse[i]),
            .clr    (wr_clr & bus_wdata[i]),
            .mask_we(wr_mask),
            .mask_d (bus_wdata[i]),
            .raw_q  (raw_q[i]),
            .mask_q (mask_q[i])
        );
    end

    sqirq_readback #(
        .NSRC  (NSRC),
        .DATA_W(DATA_W)
    ) u_rb (
        .clk  (clk),
        .rst_n(rst_n),
        .rd   (bus_rd),
        .sel  (sel),
        .raw  (raw_q),
        .mask (mask_q),
        .rdata(bus_rdata)
    );

    // Level interrupt per source.
    always_comb irq_out = raw_q & mask_q;
endmodule

// File: rtl/sqirq_checker.sv
// Property checker for seq_irq_unit, attached through bind.
// Looks only at ports and the flag/enable vectors.
module sqirq_checker #(
    parameter int NSRC     = 4,
    parameter int ADDR_W   = 12,
    parameter int DATA_W   = 32,
    parameter int RAW_OFS  = 'h004,
    parameter int MASK_OFS = 'h008,
    parameter int STAT_OFS = 'h00C
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_wr,
    input logic              bus_rd,
    input logic [DATA_W-1:0] bus_wdata,
    input logic [DATA_W-1:0] bus_rdata,
    input logic [NSRC-1:0]   evt_pulse,
    input logic [NSRC-1:0]   raw_q,
    input logic [NSRC-1:0]   mask_q
);
    logic clr_cyc;
    logic mapped;

    // Qualify status writes and mapped addresses.
    always_comb begin
        clr_cyc = bus_wr && (bus_addr == ADDR_W'(STAT_OFS));
        mapped  = (bus_addr == ADDR_W'(RAW_OFS)) || (bus_addr == ADDR_W'(MASK_OFS))
               || (bus_addr == ADDR_W'(STAT_OFS));
    end

    // R2, R7: a pulsed source is pending on the next cycle, with or without a clear.
    a_r2_evt_sets: assert property (@(posedge clk) disable iff (!rst_n)
        (|evt_pulse) |=> ((raw_q & $past(evt_pulse)) == $past(evt_pulse)));

    // R5: bits written as 1 without a same-cycle event end up cleared.
    a_r5_w1c_clears: assert property (@(posedge clk) disable iff (!rst_n)
        clr_cyc |=> ((raw_q & $past(bus_wdata[NSRC-1:0] & ~evt_pulse)) == '0));

    // R9: without an event or a status write, the flags do not move.
    a_r9_raw_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr_cyc && evt_pulse == '0) |=> $stable(raw_q));

    // R8: a write to the enable register loads its low bits.
    a_r8_mask_load: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == ADDR_W'(MASK_OFS)) |=> (mask_q == $past(bus_wdata[NSRC-1:0])));

    // R10: a read of an unmapped address returns zero.
    a_r10_unmapped_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && !mapped) |=> (bus_rdata == '0));

    // R11: the bits above the sources are never driven on reads.
    a_r11_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rdata[DATA_W-1:NSRC] == '0);
endmodule

bind seq_irq_unit sqirq_checker #(
    .NSRC(NSRC), .ADDR_W(ADDR_W), .DATA_W(DATA_W),
    .RAW_OFS(RAW_OFS), .MASK_OFS(MASK_OFS), .STAT_OFS(STAT_OFS)
) u_chk (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .evt_pulse(evt_pulse), .raw_q(raw_q), .mask_q(mask_q)
);

// File: tb/sim_seq_irq_unit.sv
// Directed bench for seq_irq_unit: one task per scenario, each self-checking.
module sim_seq_irq_unit;
    localparam logic [11:0] A_RAW  = 12'h004;
    localparam logic [11:0] A_MASK = 12'h008;
    localparam logic [11:0] A_STAT = 12'h00C;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [3:0]  evt_pulse = '0;
    logic [3:0]  irq_out;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    seq_irq_unit u0 (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .evt_pulse(evt_pulse), .irq_out(irq_out)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic bus_write(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0; bus_wdata = '0;
    endtask

    task automatic bus_read(input logic [11:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        @(negedge clk);
        bus_rd = 1'b0;
        d = bus_rdata;
    endtask

    task automatic pulse(input logic [3:0] e);
        @(negedge clk);
        evt_pulse = e;
        @(negedge clk);
        evt_pulse = '0;
    endtask

    task automatic clean();
        bus_write(A_MASK, 32'h0);
        bus_write(A_STAT, 32'hF);
    endtask

    task automatic t_reset();
        logic [31:0] d;
        check("R1 irq after reset", {28'h0, irq_out}, 32'h0);
        check("R1 rdata after reset", bus_rdata, 32'h0);
        bus_read(A_RAW, d);  check("R1 raw after reset", d, 32'h0);
        bus_read(A_MASK, d); check("R1 mask after reset", d, 32'h0);
    endtask

    task automatic t_event_set();
        logic [31:0] d;
        clean();
        pulse(4'b0101);
        bus_read(A_RAW, d); check("R2 raw set by pulses", d, 32'h5);
        repeat (3) @(negedge clk);
        bus_read(A_RAW, d); check("R2 raw holds", d, 32'h5);
    endtask

    task automatic t_masked_status();
        logic [31:0] d;
        clean();
        pulse(4'b1011);
        bus_write(A_MASK, 32'h6);
        bus_read(A_STAT, d); check("R3 status = raw & mask", d, 32'h2);
        check("R4 irq level", {28'h0, irq_out}, 32'h2);
        bus_write(A_MASK, 32'hF);
        check("R4 irq follows mask", {28'h0, irq_out}, 32'hB);
    endtask

    task automatic t_w1c();
        logic [31:0] d;
        clean();
        bus_write(A_MASK, 32'hF);
        pulse(4'hF);
        bus_write(A_STAT, 32'h9);
        bus_read(A_RAW, d); check("R5 w1c clears only ones", d, 32'h6);
        check("R5 irq after clear", {28'h0, irq_out}, 32'h6);
        bus_write(A_STAT, 32'h0);
        bus_read(A_RAW, d); check("R5 zero write no effect", d, 32'h6);
    endtask

    task automatic t_clear_unmasked();
        logic [31:0] d;
        clean();
        pulse(4'b1100);
        bus_read(A_STAT, d); check("R6 status zero when unmasked", d, 32'h0);
        bus_write(A_STAT, 32'h4);
        bus_read(A_RAW, d); check("R6 clear while unmasked", d, 32'h8);
    endtask

    task automatic t_set_wins();
        logic [31:0] d;
        clean();
        pulse(4'b0001);
        @(negedge clk);
        bus_addr = A_STAT; bus_wdata = 32'h3; bus_wr = 1'b1; evt_pulse = 4'b0010;
        @(negedge clk);
        bus_wr = 1'b0; bus_wdata = '0; evt_pulse = '0;
        bus_read(A_RAW, d); check("R7 set beats clear", d, 32'h2);
    endtask

    task automatic t_mask_rw();
        logic [31:0] d;
        clean();
        bus_write(A_MASK, 32'hFFFF_FFFA);
        bus_read(A_MASK, d); check("R8 mask readback", d, 32'hA);
    endtask

    task automatic t_raw_readonly();
        logic [31:0] d;
        clean();
        pulse(4'b0001);
        bus_write(A_RAW, 32'hE);
        bus_read(A_RAW, d); check("R9 raw write ignored (ones)", d, 32'h1);
        bus_write(A_RAW, 32'h0);
        bus_read(A_RAW, d); check("R9 raw write ignored (zero)", d, 32'h1);
    endtask

    task automatic t_unmapped();
        logic [31:0] d;
        clean();
        pulse(4'hF);
        bus_write(A_MASK, 32'hF);
        bus_read(12'h000, d); check("R10 unmapped 0x000", d, 32'h0);
        bus_read(12'h010, d); check("R10 unmapped 0x010", d, 32'h0);
        bus_read(A_RAW, d);
        repeat (2) @(negedge clk);
        check("R10 rdata held between reads", bus_rdata, 32'hF);
    endtask

    task automatic t_reserved();
        logic [31:0] d;
        clean();
        pulse(4'hF);
        bus_write(A_MASK, 32'hF);
        bus_write(A_STAT, 32'hFFFF_FFF0);
        bus_read(A_STAT, d); check("R11 upper write ignored", d, 32'hF);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_event_set();
        t_masked_status();
        t_w1c();
        t_clear_unmasked();
        t_set_wins();
        t_mask_rw();
        t_raw_readonly();
        t_unmapped();
        t_reserved();
        done = 1'b1;
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("  Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule